// File: doc/BRIEF.md
# Cascadable Presettable Divide-by-N Down Counter

This block is a 4-bit synchronous binary down counter for frequency division. It runs on a fast system clock. It watches a slower external count clock and a count-inhibit line through synchronisers and turns their edges into single-cycle decrement steps. A rising count clock decrements the value while inhibit is low. A falling inhibit while the count clock is high also decrements it, so inhibit can serve as a second, negative-edge clock. A high inhibit level otherwise blocks counting.

A load input is not synchronised. While it is high, the count output shows the preset value at once through a combinational path, and the stored count takes that value on the next system clock edge. The terminal flag is decoded from the stored count and gated by a cascade input. For a single stage, the flag is looped back into the load input, which gives division by the preset value N. Stages chain into one wider divider without glue gates: an upstream flag feeds the downstream cascade input, and the last flag drives every load input.

Top module: `cdiv_stage`

## Requirements
- R1: While rst_ni is low, the stored count is 0 at once, without waiting for a clock edge. The synchronised internal reset releases two system clock edges after rst_ni rises.
- R2: A rising edge on cnt_clk_i while inhibit_i is low decrements count_o by exactly one. The new value is visible after the third rising system clock edge that follows the input change.
- R3: A rising edge on cnt_clk_i while inhibit_i is high leaves count_o unchanged.
- R4: A falling edge on inhibit_i while cnt_clk_i is high decrements count_o by one. A rising inhibit edge, or a falling inhibit edge while cnt_clk_i is low, leaves the count unchanged.
- R5: While load_i is high, count_o equals preset_i immediately and count edges are ignored. The stored count takes preset_i on the next system clock edge and keeps it after load_i falls.
- R6: A decrement from 0 (4'b0000) gives 15 (4'b1111).
- R7: zero_o is high exactly when the stored count is 0 and cascade_i is high.
- R8: With zero_o looped to load_i and cascade_i high, zero_o pulses once every N count edges for a preset N. A preset of 0 holds zero_o high permanently.
- R9: Two stages are chained as follows. The high stage has cascade_i high and its zero_o drives the cascade_i of the low stage. The low stage's zero_o drives both load inputs. The high stage's inhibit is held low only across count-clock edges where the low count is 0. This chain divides by the 8-bit value {high preset, low preset}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used for sampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_clk_i | input | 1 | External count clock; counts on its rising edge |
| inhibit_i | input | 1 | High blocks counting; its falling edge counts while cnt_clk_i is high |
| load_i | input | 1 | Asynchronous preset load, active high |
| cascade_i | input | 1 | Qualifier for the terminal flag |
| preset_i | input | 4 | Value to load |
| count_o | output | 4 | Current count; shows preset_i while loading |
| zero_o | output | 1 | Stored count is zero and cascade_i is high |

## Verification
A count edge on cnt_clk_i or inhibit_i passes through two synchroniser flops and one edge-history flop. The count and the terminal flag therefore change on the third system clock edge after the input moves. The bench waits five system cycles after every edge before it hands an expected item to the scoreboard. The scoreboard compares only on falling system clock edges. A load shows on count_o in the same cycle, and a cascade change shows on zero_o in the same cycle, so those items are queued one falling edge after the stimulus. The division-ratio checks count terminal-flag rises across whole count-clock periods. They sample at N-1 and at N periods, which catches off-by-one errors.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int unsigned DEF_WIDTH       = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_CLK  = 2'd1,
    STEP_INH  = 2'd2
  } step_src_e;
endpackage

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/cdiv_sync.sv
module cdiv_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_d = d_i;
    end else begin : g_multi
      always_comb sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cdiv_step.sv
module cdiv_step
  import cdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_clk_i,
  input  logic inhibit_i,
  output logic step_o
);
  localparam int unsigned ARM_LIMIT = SYNC_STAGES + 1;
  localparam int unsigned ARM_W     = $clog2(ARM_LIMIT + 1);

  logic             clk_s, inh_s;
  logic             clk_prev_q, inh_prev_q;
  logic [ARM_W-1:0] arm_q, arm_d;
  logic             arm_en, armed;
  logic             clk_rise, inh_fall;
  step_src_e        src;

  cdiv_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(cnt_clk_i), .q_o(clk_s)
  );
  cdiv_sync #(.STAGES(SYNC_STAGES)) u_sync_inh (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(inhibit_i), .q_o(inh_s)
  );

  // edge history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_prev_q <= 1'b0;
      inh_prev_q <= 1'b0;
    end else begin
      clk_prev_q <= clk_s;
      inh_prev_q <= inh_s;
    end
  end

  // arming: no edges are reported until the sampling chain holds real data
  assign armed  = (arm_q == ARM_W'(ARM_LIMIT));
  assign arm_en = !armed;
  always_comb arm_d = arm_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     arm_q <= '0;
    else if (arm_en) arm_q <= arm_d;
  end

  assign clk_rise = clk_s & ~clk_prev_q;
  assign inh_fall = inh_prev_q & ~inh_s;

  always_comb begin
    src = STEP_NONE;
    if (clk_rise && !inh_s)     src = STEP_CLK;
    else if (inh_fall && clk_s) src = STEP_INH;
  end

  assign step_o = armed && (src != STEP_NONE);
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] count_q_o
);
  logic [WIDTH-1:0] count_q, count_d;
  logic             upd_en;

  assign upd_en = load_i | step_i;

  always_comb begin
    if (load_i) count_d = preset_i;
    else        count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (upd_en) count_q <= count_d;
  end

  assign count_o   = load_i ? preset_i : count_q;
  assign count_q_o = count_q;
endmodule

// File: rtl/cdiv_zero.sv
module cdiv_zero #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             cascade_i,
  output logic             zero_o
);
  assign zero_o = cascade_i & ~(|count_i);
endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage
  import cdiv_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_clk_i,
  input  logic             inhibit_i,
  input  logic             load_i,
  input  logic             cascade_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             zero_o
);
  logic             rst_n;
  logic             step;
  logic [WIDTH-1:0] count_q;

  cdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  cdiv_step #(.SYNC_STAGES(SYNC_STAGES)) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .cnt_clk_i(cnt_clk_i),
    .inhibit_i(inhibit_i),
    .step_o   (step)
  );

  cdiv_core #(.WIDTH(WIDTH)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (load_i),
    .preset_i (preset_i),
    .step_i   (step),
    .count_o  (count_o),
    .count_q_o(count_q)
  );

  cdiv_zero #(.WIDTH(WIDTH)) u_zero (
    .count_i  (count_q),
    .cascade_i(cascade_i),
    .zero_o   (zero_o)
  );
endmodule

// File: rtl/cdiv_stage_chk.sv
module cdiv_stage_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_n,
  input logic             load_i,
  input logic [WIDTH-1:0] preset_i,
  input logic [WIDTH-1:0] count_o,
  input logic [WIDTH-1:0] count_q,
  input logic             step,
  input logic             zero_o
);
  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> count_q == '0);

  p_step_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    step && !load_i |=> count_q == WIDTH'($past(count_q) - 1'b1));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !step && !load_i |=> $stable(count_q));

  p_load_take_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_i |=> count_q == $past(preset_i));

  p_zero_means_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    zero_o && !load_i |-> count_o == '0);
endmodule

bind cdiv_stage cdiv_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rst_n   (rst_n),
  .load_i  (load_i),
  .preset_i(preset_i),
  .count_o (count_o),
  .count_q (count_q),
  .step    (step),
  .zero_o  (zero_o)
);

// File: tb/cdiv_stage_tb.sv
module cdiv_stage_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       rst_n, ec;
  logic       d_inh, d_load, d_casc;
  logic [3:0] d_pre, d_cnt;
  logic       d_zero;

  logic [3:0] loop_pre, loop_cnt;
  logic       loop_z;
  logic [7:0] casc_pre;
  logic [3:0] hi_cnt, lo_cnt;
  logic       hi_z, lo_z;
  logic       hi_inh = 1'b1;

  int n_chk = 0, n_err = 0;

  cdiv_stage u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(ec), .inhibit_i(d_inh),
    .load_i(d_load), .cascade_i(d_casc), .preset_i(d_pre),
    .count_o(d_cnt), .zero_o(d_zero)
  );

  cdiv_stage u_loop (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(ec), .inhibit_i(1'b0),
    .load_i(loop_z), .cascade_i(1'b1), .preset_i(loop_pre),
    .count_o(loop_cnt), .zero_o(loop_z)
  );

  cdiv_stage u_hi (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(ec), .inhibit_i(hi_inh),
    .load_i(lo_z), .cascade_i(1'b1), .preset_i(casc_pre[7:4]),
    .count_o(hi_cnt), .zero_o(hi_z)
  );

  cdiv_stage u_lo (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(ec), .inhibit_i(1'b0),
    .load_i(lo_z), .cascade_i(hi_z), .preset_i(casc_pre[3:0]),
    .count_o(lo_cnt), .zero_o(lo_z)
  );

  // borrow enable for the high stage, changed only while the count clock is low
  always @(negedge ec) hi_inh <= (lo_cnt != 4'd0);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {string req; int cnt; int zr;} exp_t;
  exp_t sb_q[$];
  exp_t mon_e;

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      mon_e = sb_q.pop_front();
      check(mon_e.req, int'(d_cnt), mon_e.cnt);
      check(mon_e.req, int'(d_zero), mon_e.zr);
    end
  end

  task automatic expect_out(string req, int c, int z);
    sb_q.push_back('{req, c, z});
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    ec = 1'b1; settle(5);
    ec = 1'b0; settle(5);
  endtask

  // terminal-flag rise counters
  logic lz_d = 1'b0, cz_d = 1'b0;
  int   l_rise = 0, c_rise = 0;
  always @(negedge clk) begin
    lz_d <= loop_z;
    cz_d <= lo_z;
    if (loop_z && !lz_d) l_rise <= l_rise + 1;
    if (lo_z && !cz_d)   c_rise <= c_rise + 1;
  end

  task automatic casc_ratio(int p);
    int base;
    base = c_rise;
    while (c_rise == base) tick();
    base = c_rise;
    repeat (2*p - 1) tick();
    check("R9", c_rise - base, 1);
    tick();
    check("R9", c_rise - base, 2);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int base, lows;
    rst_n = 1'b0; ec = 1'b0; d_inh = 1'b0; d_load = 1'b0; d_casc = 1'b1;
    d_pre = 4'd0; loop_pre = 4'd5; casc_pre = 8'h23;
    settle(3);
    expect_out("R1", 0, 1);
    rst_n = 1'b1;
    settle(8);

    // R5 load and hold
    d_pre = 4'd9; d_load = 1'b1;
    @(negedge clk);
    expect_out("R5", 9, 0);
    tick();
    expect_out("R5", 9, 0);
    d_load = 1'b0; settle(2);
    expect_out("R5", 9, 0);

    // R2 normal count
    tick(); expect_out("R2", 8, 0);
    tick(); expect_out("R2", 7, 0);

    // R3 inhibit level
    d_inh = 1'b1; settle(6);
    tick(); expect_out("R3", 7, 0);
    ec = 1'b1; settle(6);
    expect_out("R3", 7, 0);

    // R4 inhibit as negative-edge clock
    d_inh = 1'b0; settle(6);
    expect_out("R4", 6, 0);
    d_inh = 1'b1; settle(6);
    expect_out("R4", 6, 0);
    ec = 1'b0; settle(6);
    d_inh = 1'b0; settle(6);
    expect_out("R4", 6, 0);

    // R7 zero decode and cascade gating
    d_pre = 4'd1; d_load = 1'b1;
    @(negedge clk);
    d_load = 1'b0; settle(3);
    expect_out("R5", 1, 0);
    tick(); expect_out("R7", 0, 1);
    d_casc = 1'b0; @(negedge clk);
    expect_out("R7", 0, 0);
    d_casc = 1'b1; @(negedge clk);

    // R6 wrap
    tick(); expect_out("R6", 15, 0);
    tick(); expect_out("R2", 14, 0);

    // R5 load wins over a simultaneous edge
    d_pre = 4'd3; d_load = 1'b1; ec = 1'b1; settle(6);
    d_load = 1'b0; settle(2);
    expect_out("R5", 3, 0);
    ec = 1'b0; settle(6);
    expect_out("R5", 3, 0);

    // R1 reset mid-run
    rst_n = 1'b0; @(negedge clk);
    expect_out("R1", 0, 1);
    rst_n = 1'b1; settle(8);

    // R8 single-stage division by 5
    base = l_rise;
    while (l_rise == base) tick();
    base = l_rise;
    repeat (14) tick();
    check("R8", l_rise - base, 2);
    tick();
    check("R8", l_rise - base, 3);

    // R8 preset 0 keeps the flag high
    loop_pre = 4'd0;
    repeat (8) tick();
    lows = 0;
    fork
      repeat (4) tick();
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!loop_z) lows++;
      end
    join
    check("R8", lows, 0);

    // R9 two-stage chain
    casc_ratio(35);
    casc_pre = 8'h10;
    casc_ratio(16);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule